// File: doc/BRIEF.md
# Host Indirect Memory Access Port

This block is a slave port through which an external host reaches a processor's on-chip program and data memories over one 16-bit bus that carries both addresses and data. The host first latches a control word. This word either sets a start address together with a memory-type flag, or loads an overlay-page register. The host then issues a stream of read or write strobes. The stored address steps forward by itself after each completed word, so a block of consecutive locations needs only its start address. The host never reads the stored address back.

All four host strobes are asynchronous. Each one passes through a two-flop synchroniser, and the port acts only on synchronised edges. A central state machine runs every transfer through four named states:

- `ST_IDLE` (ready). `ST_IDLE -> ST_ACCESS` is taken on a read or write rising edge while select is high.
- `ST_ACCESS`, which issues the single-cycle memory request. `ST_ACCESS -> ST_FINISH` is taken always.
- `ST_FINISH`, which captures read data and advances the address. `ST_FINISH -> ST_RELEASE` is taken always.
- `ST_RELEASE`, which waits for the strobe to drop. `ST_RELEASE -> ST_IDLE` is taken once both read and write are low.

A 24-bit program word moves as two bus transfers. The port also keeps a boot-hold flag. In boot-from-host mode this flag keeps the core stalled until the host writes program location 0.

Top module: `hostmem_port`

## Requirements
- R1: After reset `host_ack` is 1, neither memory request is active, `ovl_page` is 0, and `boot_hold` equals `boot_from_host`.
- R2: A synchronised falling edge of `host_alat` while `host_sel` is high latches the bus word. When bit 15 is 0, bits 13:0 become the start address and bit 14 the type (0 = program, 1 = data), and the program-word half pointer resets to the upper half.
- R3: A latched word with bit 15 = 1 loads bits 14:0 into `ovl_page` and leaves address and type unchanged.
- R4: An address-latch falling edge while `host_sel` is low has no effect.
- R5: A data-memory write stores `host_ad_in` at the current address with one request, then increments the address.
- R6: A data-memory read returns the word at the current address on `host_ad_out`, then increments the address.
- R7: A program-memory write takes two transfers. The first supplies bits 23:8, the second supplies bits 7:0 in bus bits 7:0. A single memory write happens on the second transfer, and the address increments only after it.
- R8: A program-memory read takes two transfers. The first returns bits 23:8, the second returns bits 7:0 with bus bits 15:8 at zero, and the address increments after the second.
- R9: `host_ack` drops once a synchronised read or write edge is seen and stays low until the access completes. Memory requests last one cycle and are never both active.
- R10: `boot_hold` clears, and stays clear, once a program write to address 0 completes. Program writes to other addresses do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| boot_from_host | input | 1 | Boot-from-host mode select |
| host_sel | input | 1 | Host select (async, active high) |
| host_alat | input | 1 | Host address-latch strobe (async, active high) |
| host_rd | input | 1 | Host read strobe (async, active high) |
| host_wr | input | 1 | Host write strobe (async, active high) |
| host_ad_in | input | 16 | Address/data from host |
| host_ad_out | output | 16 | Read data to host |
| host_ad_oe | output | 1 | Read data drive enable |
| host_ack | output | 1 | Acknowledge, high when port ready |
| pm_req | output | 1 | Program memory request |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | 14 | Program memory address |
| pm_wdata | output | 24 | Program memory write data |
| pm_rdata | input | 24 | Program memory read data, one cycle after request |
| dm_req | output | 1 | Data memory request |
| dm_we | output | 1 | Data memory write enable |
| dm_addr | output | 14 | Data memory address |
| dm_wdata | output | 16 | Data memory write data |
| dm_rdata | input | 16 | Data memory read data, one cycle after request |
| ovl_page | output | 15 | Overlay page register |
| boot_hold | output | 1 | Core execution hold |

## Verification
A wrong stored address or type has no port of its own to show on. It surfaces only at the next data strobe, where the memory request lands at the wrong location or in the wrong array. The bench therefore checks every burst word at its memory location and in its read order. A half-pointer fault swaps upper and lower program bytes, or writes twice, on the very next 24-bit word. A state-machine fault shows within a few cycles of a strobe, as an acknowledge that never drops or never returns.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 14;
    localparam int PM_W   = 24;
    localparam int OVL_W  = 15;
    localparam int NSTB   = 4;
    localparam int STB_SEL = 0;
    localparam int STB_ALT = 1;
    localparam int STB_RD  = 2;
    localparam int STB_WR  = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_FINISH  = 2'd2,
        ST_RELEASE = 2'd3
    } port_state_t;
endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] pipe [STAGES];
    logic [WIDTH-1:0] prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= pipe[STAGES-1];
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~prev;
    assign fall = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/hmp_addr_unit.sv
module hmp_addr_unit
    import hmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_from_host,
    input  logic              latch_ev,
    input  logic [BUS_W-1:0]  latch_word,
    input  logic              xfer_done,
    input  logic              xfer_write,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_dm,
    output logic              cur_half,
    output logic [OVL_W-1:0]  ovl_q,
    output logic              boot_hold
);
    logic hold_q;
    logic addr_sel;
    logic ovl_sel;
    logic step_addr;

    assign addr_sel  = latch_ev && !latch_word[BUS_W-1];
    assign ovl_sel   = latch_ev &&  latch_word[BUS_W-1];
    assign step_addr = xfer_done && (cur_dm || cur_half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_dm   <= 1'b0;
            cur_half <= 1'b0;
        end else if (addr_sel) begin
            cur_addr <= latch_word[ADDR_W-1:0];
            cur_dm   <= latch_word[ADDR_W];
            cur_half <= 1'b0;
        end else if (xfer_done) begin
            if (step_addr) cur_addr <= cur_addr + 1'b1;
            cur_half <= cur_dm ? 1'b0 : !cur_half;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovl_q <= '0;
        else if (ovl_sel) ovl_q <= latch_word[OVL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b1;
        else if (xfer_done && xfer_write && !cur_dm && cur_half && cur_addr == '0)
            hold_q <= 1'b0;
    end

    assign boot_hold = boot_from_host && hold_q;

    assert_overlay_keeps_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_sel |=> (cur_addr == $past(cur_addr) && cur_dm == $past(cur_dm)));

    assert_dm_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && cur_dm && !latch_ev) |=> cur_addr == $past(cur_addr) + 1'b1);

    assert_boot_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_q |=> !hold_q);
endmodule

// File: rtl/hmp_fsm.sv
module hmp_fsm
    import hmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              rd_s,
    input  logic              wr_s,
    input  logic              rd_rise,
    input  logic              wr_rise,
    input  logic              cur_dm,
    input  logic              cur_half,
    input  logic [BUS_W-1:0]  host_ad_in,
    input  logic [PM_W-1:0]   pm_rdata,
    input  logic [BUS_W-1:0]  dm_rdata,
    output logic              host_ack,
    output logic              idle,
    output logic              pm_req,
    output logic              pm_we,
    output logic [PM_W-1:0]   pm_wdata,
    output logic              dm_req,
    output logic              dm_we,
    output logic [BUS_W-1:0]  dm_wdata,
    output logic              xfer_done,
    output logic              xfer_write,
    output logic [BUS_W-1:0]  rd_word
);
    localparam int LOW_W = PM_W - BUS_W;

    port_state_t state_q, state_d;
    logic             is_wr_q;
    logic [BUS_W-1:0] upper_q;
    logic [LOW_W-1:0] lower_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (sel_s && (rd_rise || wr_rise)) state_d = ST_ACCESS;
            ST_ACCESS:  state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_RELEASE;
            ST_RELEASE: if (!rd_s && !wr_s) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        host_ack   = 1'b0;
        idle       = 1'b0;
        pm_req     = 1'b0;
        dm_req     = 1'b0;
        xfer_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                host_ack = 1'b1;
                idle     = 1'b1;
            end
            ST_ACCESS: begin
                dm_req = cur_dm;
                pm_req = !cur_dm && (is_wr_q == cur_half);
            end
            ST_FINISH:  xfer_done = 1'b1;
            ST_RELEASE: host_ack  = 1'b1;
        endcase
        pm_we      = is_wr_q;
        dm_we      = is_wr_q;
        xfer_write = is_wr_q;
        pm_wdata   = {upper_q, host_ad_in[LOW_W-1:0]};
        dm_wdata   = host_ad_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_wr_q <= 1'b0;
            upper_q <= '0;
            lower_q <= '0;
            rd_word <= '0;
        end else begin
            if (state_q == ST_IDLE && sel_s && (rd_rise || wr_rise))
                is_wr_q <= wr_rise;
            if (state_q == ST_ACCESS && is_wr_q && !cur_dm && !cur_half)
                upper_q <= host_ad_in;
            if (state_q == ST_FINISH && !is_wr_q) begin
                if (cur_dm) begin
                    rd_word <= dm_rdata;
                end else if (!cur_half) begin
                    rd_word <= pm_rdata[PM_W-1:LOW_W];
                    lower_q <= pm_rdata[LOW_W-1:0];
                end else begin
                    rd_word <= {{(BUS_W-LOW_W){1'b0}}, lower_q};
                end
            end
        end
    end
endmodule

// File: rtl/hostmem_port.sv
module hostmem_port
    import hmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_from_host,
    input  logic              host_sel,
    input  logic              host_alat,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [15:0]       host_ad_in,
    output logic [15:0]       host_ad_out,
    output logic              host_ad_oe,
    output logic              host_ack,
    output logic              pm_req,
    output logic              pm_we,
    output logic [13:0]       pm_addr,
    output logic [23:0]       pm_wdata,
    input  logic [23:0]       pm_rdata,
    output logic              dm_req,
    output logic              dm_we,
    output logic [13:0]       dm_addr,
    output logic [15:0]       dm_wdata,
    input  logic [15:0]       dm_rdata,
    output logic [14:0]       ovl_page,
    output logic              boot_hold
);
    logic [NSTB-1:0] raw, lvl, rise, fall;
    logic              idle, xfer_done, xfer_write, latch_ev;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_dm, cur_half;

    always_comb begin
        raw          = '0;
        raw[STB_SEL] = host_sel;
        raw[STB_ALT] = host_alat;
        raw[STB_RD]  = host_rd;
        raw[STB_WR]  = host_wr;
    end

    hmp_sync #(.WIDTH(NSTB), .STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw(raw),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    assign latch_ev = idle && lvl[STB_SEL] && fall[STB_ALT];

    hmp_addr_unit addr_i (
        .clk(clk), .rst_n(rst_n), .boot_from_host(boot_from_host),
        .latch_ev(latch_ev), .latch_word(host_ad_in),
        .xfer_done(xfer_done), .xfer_write(xfer_write),
        .cur_addr(cur_addr), .cur_dm(cur_dm), .cur_half(cur_half),
        .ovl_q(ovl_page), .boot_hold(boot_hold)
    );

    hmp_fsm fsm_i (
        .clk(clk), .rst_n(rst_n),
        .sel_s(lvl[STB_SEL]), .rd_s(lvl[STB_RD]), .wr_s(lvl[STB_WR]),
        .rd_rise(rise[STB_RD]), .wr_rise(rise[STB_WR]),
        .cur_dm(cur_dm), .cur_half(cur_half),
        .host_ad_in(host_ad_in), .pm_rdata(pm_rdata), .dm_rdata(dm_rdata),
        .host_ack(host_ack), .idle(idle),
        .pm_req(pm_req), .pm_we(pm_we), .pm_wdata(pm_wdata),
        .dm_req(dm_req), .dm_we(dm_we), .dm_wdata(dm_wdata),
        .xfer_done(xfer_done), .xfer_write(xfer_write),
        .rd_word(host_ad_out)
    );

    assign pm_addr    = cur_addr;
    assign dm_addr    = cur_addr;
    assign host_ad_oe = lvl[STB_SEL] && lvl[STB_RD];

    assert_single_array_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pm_req && dm_req));

    assert_req_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_req || dm_req) |=> !(pm_req || dm_req));

    assert_no_latch_unselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fall[STB_ALT] && !lvl[STB_SEL]) |=> (ovl_page == $past(ovl_page) && cur_addr == $past(cur_addr)));
endmodule

// File: tb/hostmem_port_tb_top.sv
module hostmem_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boot_from_host = 1'b1;
    logic host_sel = 1'b0, host_alat = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [15:0] host_ad_in = '0;
    logic [15:0] host_ad_out;
    logic host_ad_oe, host_ack;
    logic pm_req, pm_we, dm_req, dm_we, boot_hold;
    logic [13:0] pm_addr, dm_addr;
    logic [23:0] pm_wdata, pm_rdata;
    logic [15:0] dm_wdata, dm_rdata;
    logic [14:0] ovl_page;

    int total = 0;
    int fails = 0;
    logic [15:0] exp_q[$];
    event rd_ev;

    logic [23:0] pm_mem [256];
    logic [15:0] dm_mem [256];

    always #5 clk = ~clk;

    hostmem_port dut_i (.*);

    always @(posedge clk) begin
        if (pm_req) begin
            if (pm_we) pm_mem[pm_addr[7:0]] <= pm_wdata;
            else       pm_rdata <= pm_mem[pm_addr[7:0]];
        end
        if (dm_req) begin
            if (dm_we) dm_mem[dm_addr[7:0]] <= dm_wdata;
            else       dm_rdata <= dm_mem[dm_addr[7:0]];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic latch_word(input logic [15:0] w, input logic sel);
        @(negedge clk);
        host_ad_in = w; host_sel = sel; host_alat = 1'b1;
        repeat (4) @(negedge clk);
        host_alat = 1'b0;
        repeat (5) @(negedge clk);
        host_sel = 1'b1;
    endtask

    task automatic strobe(input logic is_wr);
        bit saw_low = 0;
        @(negedge clk);
        if (is_wr) host_wr = 1'b1; else host_rd = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!host_ack) saw_low = 1;
            else if (saw_low) break;
        end
        check("R9 ack dropped and returned", {saw_low, host_ack}, 2'b11);
        if (!is_wr) -> rd_ev;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic host_write(input logic [15:0] d);
        host_ad_in = d;
        strobe(1'b1);
    endtask

    task automatic host_read(input logic [15:0] exp);
        exp_q.push_back(exp);
        strobe(1'b0);
    endtask

    initial begin
        forever begin
            @(rd_ev);
            if (exp_q.size() == 0) check("R6/R8 unexpected read", 1, 0);
            else check("R6/R8 read data", host_ad_out, exp_q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin pm_mem[i] = '0; dm_mem[i] = '0; end
        repeat (3) @(negedge clk);
        check("R1 ack", host_ack, 1);
        check("R1 no request", {pm_req, dm_req}, 0);
        check("R1 overlay", ovl_page, 0);
        check("R1 boot hold", boot_hold, 1);
        rst_n = 1'b1;
        @(negedge clk);
        host_sel = 1'b1;

        // R2, R5: data burst write from address 5 (bit14=1 selects data)
        latch_word(16'h4005, 1'b1);
        host_write(16'h1111); host_write(16'h2222); host_write(16'h3333);
        check("R5 dm[5]", dm_mem[5], 16'h1111);
        check("R5 dm[6]", dm_mem[6], 16'h2222);
        check("R2 R5 dm[7]", dm_mem[7], 16'h3333);

        // R6: data burst read
        latch_word(16'h4005, 1'b1);
        host_read(16'h1111); host_read(16'h2222); host_read(16'h3333);

        // R4: latch without select is ignored; address continues at 8
        latch_word(16'h4020, 1'b0);
        host_write(16'h4444);
        check("R4 write at continued address", dm_mem[8], 16'h4444);
        check("R4 ignored address untouched", dm_mem[32], 16'h0000);

        // R3: overlay load keeps address
        latch_word(16'h400A, 1'b1);
        latch_word(16'h8123, 1'b1);
        check("R3 overlay value", ovl_page, 15'h0123);
        host_write(16'h5555);
        check("R3 address kept", dm_mem[10], 16'h5555);

        // R7, R10: program writes (bit14=0)
        latch_word(16'h0001, 1'b1);
        host_write(16'hABCD);
        check("R7 no write after first half", pm_mem[1], 24'h0);
        host_write(16'h00EF);
        check("R7 pm[1]", pm_mem[1], 24'hABCDEF);
        check("R10 hold kept for address 1", boot_hold, 1);
        host_write(16'h1234); host_write(16'h0056);
        check("R7 pm[2] single increment", pm_mem[2], 24'h123456);
        latch_word(16'h0000, 1'b1);
        host_write(16'h7777);
        check("R10 hold kept after first half", boot_hold, 1);
        host_write(16'h0088);
        check("R7 pm[0]", pm_mem[0], 24'h777788);
        check("R10 hold released", boot_hold, 0);

        // R8: program reads
        latch_word(16'h0001, 1'b1);
        host_read(16'hABCD); host_read(16'h00EF); host_read(16'h1234); host_read(16'h0056);
        check("R8 queue drained", exp_q.size(), 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule